// File: doc/BRIEF.md
# Speculative Load/Store Address Resolution Buffer

This block sits between a ring of speculative tasks and memory. Tasks issue word loads and stores through one request port. A load is never held back by stores of older tasks. It is answered in the same cycle, either from the closest older task's buffered store to that word or from memory. A non-head load also marks its address with a per-task load bit. A store is kept in a per-task data slot of the entry for its address. If a younger task has already loaded that word, the store is a dependence violation, and the oldest such younger task is squashed.

Task order follows the ring. A task's age is (task - head) mod TASKS, and a smaller age means an older task. Stores never reach memory while their task is speculative. When the head task is done, a commit pulse drains its buffered stores to the memory write port one per cycle. The block then clears the head task's bits and moves the head one step around the ring. Entries are fully associative and are allocated on demand. A non-head request that needs a new entry stalls while none is free. The head task is never stalled.

Top module: `spec_addr_buf`

## Requirements
- R1: A load to a word that holds no buffered store from a task of equal or smaller age returns mem_rd_data_i on rd_data_o in the same cycle, with rd_fwd_o low.
- R2: A load to a word that holds buffered stores from tasks of equal or smaller age returns, in the same cycle, the data of the store whose task has the largest such age, with rd_fwd_o high. Stores from younger tasks are never forwarded.
- R3: A store by task S to a word that a task younger than S has loaded raises squash_o for exactly one cycle, in the cycle after the store. squash_task_o names the youngest-but-closest violator, that is the loader with the smallest age greater than S's age.
- R4: A store raises no squash when the only loaders of that word are S itself or tasks older than S.
- R5: On a squash, the squashed task's load bits and store slots are cleared in every entry. Its stores are no longer forwarded to later loads.
- R6: A store from a non-head task never drives mem_wr_valid_o. Its data is held in the buffer.
- R7: A one-cycle commit_i pulse starts a drain. From the next cycle the head task's buffered stores appear on mem_wr_* one per cycle, lowest entry index first. One further cycle follows with no write. Then head_o steps by one (mod TASKS). drain_busy_o is high and req_ready_o is low for the whole drain.
- R8: A non-head request that hits no entry while all ENTRIES entries are in use sees req_ready_o low. A head-task request is always ready outside a drain. A head store that can get no entry is written to memory in the same cycle on mem_wr_*.
- R9: After reset, head_o is 0, squash_o, mem_wr_valid_o and drain_busy_o are low, and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_task_i | input | TW | Ring slot of the requesting task |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data |
| req_ready_o | output | 1 | Request accepted this cycle |
| rd_data_o | output | DW | Load result (combinational) |
| rd_fwd_o | output | 1 | Load result came from a buffered store |
| mem_rd_addr_o | output | AW | Memory read address |
| mem_rd_data_i | input | DW | Memory read data, same cycle |
| mem_wr_valid_o | output | 1 | Memory write strobe |
| mem_wr_addr_o | output | AW | Memory write address |
| mem_wr_data_o | output | DW | Memory write data |
| squash_o | output | 1 | Violation detected, one-cycle pulse |
| squash_task_o | output | TW | Task to squash |
| commit_i | input | 1 | Head task finished, start drain |
| head_o | output | TW | Current head task |
| drain_busy_o | output | 1 | Drain in progress |

## Verification
The hardest situation to reach is a word that several tasks of different ages have both loaded and stored. Only there do the squash choice and the forwarding choice depend on ring age, not on mere presence. The stimulus builds up such a word one request at a time. It then checks that a squash removes the victim's own store, by loading the word from a task that would otherwise have been served that store. It also checks that a later squash takes away an older task's store, so a following load falls back to memory. Buffer exhaustion needs all sixteen entries live at once. The bench fills them with stores from a single task, then tries a non-head load, a head load and a head store at a new address.

// File: rtl/sab_pkg.sv
package sab_pkg;
  typedef enum logic {
    DR_IDLE  = 1'b0,
    DR_DRAIN = 1'b1
  } drain_state_e;
endpackage

// File: rtl/sab_pick.sv
module sab_pick #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sab_entry.sv
module sab_entry #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TASKS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic [TASKS-1:0]          set_ld_i,
  input  logic [TASKS-1:0]          set_st_i,
  input  logic [TASKS-1:0]          clr_task_i,
  input  logic [TASKS-1:0]          clr_st_i,
  output logic                      valid_o,
  output logic [AW-1:0]             addr_o,
  output logic [TASKS-1:0]          ld_o,
  output logic [TASKS-1:0]          st_o,
  output logic [TASKS-1:0][DW-1:0]  data_o
);
  logic [AW-1:0]            addr_q;
  logic [TASKS-1:0]         ld_q, st_q;
  logic [TASKS-1:0][DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ld_q   <= '0;
      st_q   <= '0;
      data_q <= '0;
    end else begin
      if (alloc_i) addr_q <= addr_i;
      ld_q <= (ld_q & ~clr_task_i) | set_ld_i;
      st_q <= (st_q & ~clr_task_i & ~clr_st_i) | set_st_i;
      for (int t = 0; t < TASKS; t++) begin
        if (set_st_i[t]) data_q[t] <= wdata_i;
      end
    end
  end

  assign valid_o = (|ld_q) || (|st_q);
  assign addr_o  = addr_q;
  assign ld_o    = ld_q;
  assign st_o    = st_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sab_drain.sv
module sab_drain #(
  parameter int ENTRIES = 16,
  parameter int TASKS   = 4,
  localparam int EW = $clog2(ENTRIES),
  localparam int TW = $clog2(TASKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [ENTRIES-1:0] pend_i,
  output logic               busy_o,
  output logic               wr_fire_o,
  output logic [EW-1:0]      wr_idx_o,
  output logic               retire_o,
  output logic [TW-1:0]      head_o
);
  import sab_pkg::*;

  drain_state_e state_q;
  logic [TW-1:0] head_q;
  logic          pend_any;

  sab_pick #(.N(ENTRIES)) u_pick (
    .vec_i   (pend_i),
    .found_o (pend_any),
    .idx_o   (wr_idx_o)
  );

  assign busy_o    = (state_q == DR_DRAIN);
  assign wr_fire_o = busy_o && pend_any;
  assign retire_o  = busy_o && !pend_any;
  assign head_o    = head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DR_IDLE;
      head_q  <= '0;
    end else begin
      case (state_q)
        DR_IDLE:  if (commit_i) state_q <= DR_DRAIN;
        DR_DRAIN: if (retire_o) begin
          state_q <= DR_IDLE;
          head_q  <= head_q + 1'b1;
        end
        default:  state_q <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spec_addr_buf.sv
module spec_addr_buf #(
  parameter int ENTRIES = 16,
  parameter int TASKS   = 4,
  parameter int AW      = 16,
  parameter int DW      = 32,
  localparam int TW = $clog2(TASKS),
  localparam int EW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          req_store_i,
  input  logic [TW-1:0] req_task_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_fwd_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          mem_wr_valid_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  output logic          squash_o,
  output logic [TW-1:0] squash_task_o,
  input  logic          commit_i,
  output logic [TW-1:0] head_o,
  output logic          drain_busy_o
);
  // ring age: 0 is the head, larger is younger
  function automatic logic [TW-1:0] ring_age(logic [TW-1:0] t, logic [TW-1:0] h);
    return t - h;
  endfunction

  // closest store at or older than the requester: {found, task}
  function automatic logic [TW:0] nearest_older(logic [TASKS-1:0] st,
                                                logic [TW-1:0] who,
                                                logic [TW-1:0] h);
    logic          found;
    logic [TW-1:0] best, bage;
    found = 1'b0; best = '0; bage = '0;
    for (int t = 0; t < TASKS; t++) begin
      if (st[t] && ring_age(TW'(t), h) <= ring_age(who, h) &&
          (!found || ring_age(TW'(t), h) > bage)) begin
        found = 1'b1;
        best  = TW'(t);
        bage  = ring_age(TW'(t), h);
      end
    end
    return {found, best};
  endfunction

  // oldest loader younger than the storing task: {found, task}
  function automatic logic [TW:0] oldest_younger(logic [TASKS-1:0] ld,
                                                 logic [TW-1:0] who,
                                                 logic [TW-1:0] h);
    logic          found;
    logic [TW-1:0] best, bage;
    found = 1'b0; best = '0; bage = '0;
    for (int t = 0; t < TASKS; t++) begin
      if (ld[t] && ring_age(TW'(t), h) > ring_age(who, h) &&
          (!found || ring_age(TW'(t), h) < bage)) begin
        found = 1'b1;
        best  = TW'(t);
        bage  = ring_age(TW'(t), h);
      end
    end
    return {found, best};
  endfunction

  // entry state
  logic [ENTRIES-1:0]                      e_valid;
  logic [ENTRIES-1:0][AW-1:0]              e_addr;
  logic [ENTRIES-1:0][TASKS-1:0]           e_ld, e_st;
  logic [ENTRIES-1:0][TASKS-1:0][DW-1:0]   e_data;
  logic [ENTRIES-1:0]                      match, pend;
  logic [ENTRIES-1:0]                      free_vec;

  // named internal events
  logic          hit_any, free_any, is_head, need_alloc, no_room;
  logic [EW-1:0] hit_idx, free_idx, tgt_idx;
  logic          fire, do_alloc, rec_load, buf_store, bypass_wr;
  logic          viol_now, fwd_found;
  logic [TW-1:0] viol_task, fwd_task;
  logic          wr_fire, retire;
  logic [EW-1:0] wr_idx;
  logic [TASKS-1:0] clr_mask, req_onehot, head_onehot;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign match[e]    = e_valid[e] && (e_addr[e] == req_addr_i);
    assign free_vec[e] = !e_valid[e];
    assign pend[e]     = e_st[e][head_o];

    sab_entry #(.AW(AW), .DW(DW), .TASKS(TASKS)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (do_alloc && (free_idx == EW'(e))),
      .addr_i     (req_addr_i),
      .wdata_i    (req_wdata_i),
      .set_ld_i   ((rec_load  && tgt_idx == EW'(e)) ? req_onehot : '0),
      .set_st_i   ((buf_store && tgt_idx == EW'(e)) ? req_onehot : '0),
      .clr_task_i (clr_mask),
      .clr_st_i   ((wr_fire && wr_idx == EW'(e)) ? head_onehot : '0),
      .valid_o    (e_valid[e]),
      .addr_o     (e_addr[e]),
      .ld_o       (e_ld[e]),
      .st_o       (e_st[e]),
      .data_o     (e_data[e])
    );
  end

  sab_pick #(.N(ENTRIES)) u_hit (
    .vec_i (match), .found_o (hit_any), .idx_o (hit_idx)
  );

  sab_pick #(.N(ENTRIES)) u_free (
    .vec_i (free_vec), .found_o (free_any), .idx_o (free_idx)
  );

  sab_drain #(.ENTRIES(ENTRIES), .TASKS(TASKS)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit_i),
    .pend_i    (pend),
    .busy_o    (drain_busy_o),
    .wr_fire_o (wr_fire),
    .wr_idx_o  (wr_idx),
    .retire_o  (retire),
    .head_o    (head_o)
  );

  // request decode
  assign req_onehot  = TASKS'(1) << req_task_i;
  assign head_onehot = TASKS'(1) << head_o;
  assign is_head     = (req_task_i == head_o);
  assign need_alloc  = !hit_any && (req_store_i || !is_head);
  assign no_room     = need_alloc && !free_any && !is_head;
  assign req_ready_o = !drain_busy_o && !no_room;
  assign fire        = req_valid_i && req_ready_o;
  assign tgt_idx     = hit_any ? hit_idx : free_idx;
  assign bypass_wr   = fire && req_store_i && need_alloc && !free_any;
  assign do_alloc    = fire && need_alloc && free_any;
  assign rec_load    = fire && !req_store_i && !is_head;
  assign buf_store   = fire && req_store_i && !bypass_wr;

  // forwarding and violation search on the hit entry
  always_comb begin
    {fwd_found, fwd_task}  = nearest_older(e_st[hit_idx], req_task_i, head_o);
    {viol_now, viol_task}  = oldest_younger(e_ld[hit_idx], req_task_i, head_o);
    fwd_found = fwd_found && hit_any;
    viol_now  = viol_now && hit_any && fire && req_store_i;
  end

  assign mem_rd_addr_o = req_addr_i;
  assign rd_fwd_o      = fwd_found;
  assign rd_data_o     = fwd_found ? e_data[hit_idx][fwd_task] : mem_rd_data_i;

  assign clr_mask = (viol_now ? (TASKS'(1) << viol_task) : '0) |
                    (retire   ? head_onehot                : '0);

  // memory write: drain or head write-through
  assign mem_wr_valid_o = wr_fire || bypass_wr;
  assign mem_wr_addr_o  = wr_fire ? e_addr[wr_idx] : req_addr_i;
  assign mem_wr_data_o  = wr_fire ? e_data[wr_idx][head_o] : req_wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      squash_o      <= 1'b0;
      squash_task_o <= '0;
    end else begin
      squash_o      <= viol_now;
      squash_task_o <= viol_task;
    end
  end
endmodule

// File: rtl/sab_chk.sv
module sab_chk #(
  parameter int TASKS = 4,
  localparam int TW = $clog2(TASKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          req_store_i,
  input logic [TW-1:0] req_task_i,
  input logic          req_ready_o,
  input logic          squash_o,
  input logic [TW-1:0] squash_task_o,
  input logic [TW-1:0] head_o,
  input logic          drain_busy_o,
  input logic          mem_wr_valid_o
);
  logic [TW-1:0] st_age_q;
  logic [TW-1:0] sq_age;

  always_ff @(posedge clk) begin
    if (!rst_n) st_age_q <= '0;
    else        st_age_q <= req_task_i - head_o;
  end
  assign sq_age = squash_task_o - head_o;

  p_squash_after_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> $past(req_valid_i && req_ready_o && req_store_i));

  p_squash_younger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> (sq_age > st_age_q));

  p_head_never_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_task_i == head_o && !drain_busy_o) |-> req_ready_o);

  p_stall_in_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy_o |-> !req_ready_o);

  p_spec_store_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid_o && !drain_busy_o) |->
      (req_valid_i && req_store_i && req_task_i == head_o));

  p_head_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (head_o != $past(head_o)) |->
      ((head_o - $past(head_o)) == TW'(1) && $past(drain_busy_o)));
endmodule

bind spec_addr_buf sab_chk #(.TASKS(TASKS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid_i    (req_valid_i),
  .req_store_i    (req_store_i),
  .req_task_i     (req_task_i),
  .req_ready_o    (req_ready_o),
  .squash_o       (squash_o),
  .squash_task_o  (squash_task_o),
  .head_o         (head_o),
  .drain_busy_o   (drain_busy_o),
  .mem_wr_valid_o (mem_wr_valid_o)
);

// File: tb/sim_spec_addr_buf.sv
`timescale 1ns/1ps
module sim_spec_addr_buf;
  localparam int TW = 2;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0, req_store_i = 1'b0, commit_i = 1'b0;
  logic [TW-1:0] req_task_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_ready_o, rd_fwd_o, mem_wr_valid_o, squash_o, drain_busy_o;
  logic [DW-1:0] rd_data_o, mem_rd_data_i, mem_wr_data_o;
  logic [AW-1:0] mem_rd_addr_o, mem_wr_addr_o;
  logic [TW-1:0] squash_task_o, head_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  // memory model: data is a tag plus the address
  assign mem_rd_data_i = {16'hC0DE, mem_rd_addr_o};

  spec_addr_buf u0 (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic          st;
    logic [TW-1:0] tsk;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          fwd;
    logic [DW-1:0] rdata;
    logic          sq;
    logic [TW-1:0] sqt;
  } vec_t;

  // head is 0 throughout, so a task's age equals its number
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 16'd10, 32'd0,   1'b0, 32'hC0DE000A, 1'b0, 2'd0}, // R1
    '{1'b1, 2'd1, 16'd10, 32'd111, 1'b0, 32'd0,        1'b1, 2'd2}, // R3
    '{1'b0, 2'd3, 16'd10, 32'd0,   1'b1, 32'd111,      1'b0, 2'd0}, // R2
    '{1'b0, 2'd2, 16'd10, 32'd0,   1'b1, 32'd111,      1'b0, 2'd0}, // R2
    '{1'b1, 2'd1, 16'd10, 32'd222, 1'b0, 32'd0,        1'b1, 2'd2}, // R3 oldest of two
    '{1'b1, 2'd3, 16'd20, 32'd333, 1'b0, 32'd0,        1'b0, 2'd0}, // R4
    '{1'b0, 2'd2, 16'd20, 32'd0,   1'b0, 32'hC0DE0014, 1'b0, 2'd0}, // R2 younger not used
    '{1'b1, 2'd2, 16'd20, 32'd444, 1'b0, 32'd0,        1'b0, 2'd0}, // R4 own load
    '{1'b0, 2'd3, 16'd20, 32'd0,   1'b1, 32'd333,      1'b0, 2'd0}, // R2 own store
    '{1'b1, 2'd3, 16'd10, 32'd555, 1'b0, 32'd0,        1'b0, 2'd0}, // R4 older loaders
    '{1'b0, 2'd2, 16'd10, 32'd0,   1'b1, 32'd222,      1'b0, 2'd0}, // R2 nearest older
    '{1'b1, 2'd0, 16'd30, 32'd666, 1'b0, 32'd0,        1'b0, 2'd0}, // R6 head buffered
    '{1'b0, 2'd1, 16'd30, 32'd0,   1'b1, 32'd666,      1'b0, 2'd0}, // R2
    '{1'b1, 2'd2, 16'd40, 32'd777, 1'b0, 32'd0,        1'b0, 2'd0},
    '{1'b0, 2'd2, 16'd40, 32'd0,   1'b1, 32'd777,      1'b0, 2'd0},
    '{1'b1, 2'd1, 16'd40, 32'd888, 1'b0, 32'd0,        1'b1, 2'd2}, // R3
    '{1'b0, 2'd3, 16'd40, 32'd0,   1'b1, 32'd888,      1'b0, 2'd0}, // R5 victim store gone
    '{1'b0, 2'd1, 16'd50, 32'd0,   1'b0, 32'hC0DE0032, 1'b0, 2'd0}, // R1
    '{1'b1, 2'd0, 16'd50, 32'd999, 1'b0, 32'd0,        1'b1, 2'd1}  // R3 head store
  };

  task automatic drive(input logic st, input logic [TW-1:0] t,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_store_i = st;
    req_task_i  = t;
    req_addr_i  = a;
    req_wdata_i = d;
    #1;
  endtask

  task automatic idle_after_edge();
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid_i = 1'b0;
    commit_i = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    chk("R9 head", 32'(head_o), 32'd0);
    chk("R9 squash", 32'(squash_o), 32'd0);
    chk("R9 mem_wr_valid", 32'(mem_wr_valid_o), 32'd0);
    chk("R9 drain_busy", 32'(drain_busy_o), 32'd0);
    chk("R9 ready", 32'(req_ready_o), 32'd1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    do_reset();

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].st, VECS[i].tsk, VECS[i].addr, VECS[i].data);
      chk($sformatf("R8 ready vec %0d", i), 32'(req_ready_o), 32'd1);
      chk($sformatf("R6 no mem write vec %0d", i), 32'(mem_wr_valid_o), 32'd0);
      if (!VECS[i].st) begin
        chk($sformatf("R2 fwd flag vec %0d", i), 32'(rd_fwd_o), 32'(VECS[i].fwd));
        chk($sformatf("R1 R2 load data vec %0d", i), rd_data_o, VECS[i].rdata);
      end
      idle_after_edge();
      chk($sformatf("R3 R4 squash vec %0d", i), 32'(squash_o), 32'(VECS[i].sq));
      if (VECS[i].sq)
        chk($sformatf("R3 squash task vec %0d", i), 32'(squash_task_o), 32'(VECS[i].sqt));
    end

    // drain of head task 0: entries 2 (addr 30) and 4 (addr 50)
    @(negedge clk);
    commit_i = 1'b1;
    @(posedge clk);
    #1;
    commit_i = 1'b0;
    chk("R3 squash pulse single cycle", 32'(squash_o), 32'd0);
    chk("R7 busy", 32'(drain_busy_o), 32'd1);
    chk("R7 stall", 32'(req_ready_o), 32'd0);
    chk("R7 write1 valid", 32'(mem_wr_valid_o), 32'd1);
    chk("R7 write1 addr", 32'(mem_wr_addr_o), 32'd30);
    chk("R7 write1 data", mem_wr_data_o, 32'd666);
    @(posedge clk);
    #1;
    chk("R7 write2 valid", 32'(mem_wr_valid_o), 32'd1);
    chk("R7 write2 addr", 32'(mem_wr_addr_o), 32'd50);
    chk("R7 write2 data", mem_wr_data_o, 32'd999);
    @(posedge clk);
    #1;
    chk("R7 retire cycle no write", 32'(mem_wr_valid_o), 32'd0);
    chk("R7 head held", 32'(head_o), 32'd0);
    @(posedge clk);
    #1;
    chk("R7 head stepped", 32'(head_o), 32'd1);
    chk("R7 busy cleared", 32'(drain_busy_o), 32'd0);

    // head 1: task 1 was squashed, so its store 222 at addr 10 is gone
    drive(1'b0, 2'd2, 16'd10, 32'd0);
    chk("R5 squashed store not forwarded", 32'(rd_fwd_o), 32'd0);
    chk("R5 load from memory", rd_data_o, 32'hC0DE000A);
    idle_after_edge();

    // full buffer
    do_reset();
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 2'd1, 16'(100 + i), 32'(i));
      chk($sformatf("R8 fill ready %0d", i), 32'(req_ready_o), 32'd1);
      idle_after_edge();
    end
    drive(1'b0, 2'd2, 16'd200, 32'd0);
    chk("R8 non-head stalls when full", 32'(req_ready_o), 32'd0);
    idle_after_edge();
    drive(1'b1, 2'd1, 16'd105, 32'd77);
    chk("R8 hit needs no entry", 32'(req_ready_o), 32'd1);
    idle_after_edge();
    drive(1'b0, 2'd0, 16'd200, 32'd0);
    chk("R8 head load ready when full", 32'(req_ready_o), 32'd1);
    chk("R1 head load data", rd_data_o, 32'hC0DE00C8);
    idle_after_edge();
    drive(1'b1, 2'd0, 16'd201, 32'hBEEF);
    chk("R8 head store ready when full", 32'(req_ready_o), 32'd1);
    chk("R8 head store write-through valid", 32'(mem_wr_valid_o), 32'd1);
    chk("R8 head store write-through addr", 32'(mem_wr_addr_o), 32'd201);
    chk("R8 head store write-through data", mem_wr_data_o, 32'hBEEF);
    idle_after_edge();
    drive(1'b0, 2'd2, 16'd105, 32'd0);
    chk("R2 forward after overwrite", rd_data_o, 32'd77);
    idle_after_edge();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule